// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Every frame carries one extra bit after the eight data bits, called the multiprocessor bit. One shared line can then carry two kinds of frame to several listeners: ID frames, which have the bit set, and data frames, which have it clear. On the transmit side the host loads a byte and its multiprocessor bit into a holding register. It then clears the transmit-empty flag, which commits the byte. A second byte can be loaded while the first one is still shifting out.

On the receive side, incoming frames are oversampled at sixteen times the bit rate. Each accepted frame is delivered with its multiprocessor bit. When the host arms the address filter, the receiver drops every frame until one arrives with its multiprocessor bit set. That frame clears the filter itself and is delivered, so later data frames are accepted as well. A break input pulls the line low regardless of the transmitter state. The host uses it at the end of a transfer, before it disables the transmitter.

Top module: `mp_uart`

## Requirements
- R1: After reset, and whenever the transmitter is disabled, the flags are tde_o=1 and tend_o=1. While the transmitter is disabled and break is inactive, txd_o is 1. After reset, rx_full_o, ovr_o, fer_o and filt_o are 0.
- R2: When tx_en_i rises, txd_o holds 1 for 11 bit times (176 ticks of CLK_DIV clocks each) before the first start bit can appear.
- R3: Each frame is sent in this order: one start bit 0, data bits 0 to 7 (LSB first), the multiprocessor bit taken from wr_mpb_i, and one stop bit 1. Each bit lasts 16*CLK_DIV clocks.
- R4: A pulse on tde_clr_i while tde_o=1 commits the held byte and drives tde_o to 0. tde_o returns to 1 when the shifter takes the byte, so the next byte can be committed while the current frame is still shifting out.
- R5: A commit clears tend_o. tend_o returns to 1 only after the stop bit of the last frame has finished and no committed byte is waiting.
- R6: With the filter off, a received frame sets rx_full_o and shows its data on rx_data_o and its multiprocessor bit on rx_mpb_o. A pulse on rd_ack_i clears rx_full_o.
- R7: While filt_o=1, frames whose multiprocessor bit is 0 are dropped. They leave rx_full_o, rx_data_o and filt_o unchanged.
- R8: While filt_o=1, a frame whose multiprocessor bit is 1 clears filt_o and is delivered. The frames that follow are delivered even when their multiprocessor bit is 0.
- R9: If an accepted frame completes while rx_full_o=1, ovr_o is set and rx_data_o keeps the older byte.
- R10: An accepted frame whose stop bit samples as 0 sets fer_o. A pulse on err_clr_i clears both ovr_o and fer_o.
- R11: While brk_i=1, txd_o is 0 from the next clock onward, whatever the transmitter is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| wr_i | input | 1 | Write the holding register (effective while tde_o=1) |
| wr_data_i | input | 8 | Byte to transmit |
| wr_mpb_i | input | 1 | Multiprocessor bit for that byte |
| tde_clr_i | input | 1 | Commit pulse; clears tde_o |
| tde_o | output | 1 | Holding register empty |
| tend_o | output | 1 | Transmission finished |
| rd_ack_i | input | 1 | Clears rx_full_o |
| err_clr_i | input | 1 | Clears ovr_o and fer_o |
| filt_set_i | input | 1 | Arms the address filter |
| filt_o | output | 1 | Address filter armed |
| rx_data_o | output | 8 | Last delivered byte |
| rx_mpb_o | output | 1 | Multiprocessor bit of that byte |
| rx_full_o | output | 1 | Received byte waiting |
| ovr_o | output | 1 | Overrun |
| fer_o | output | 1 | Framing error |
| brk_i | input | 1 | Forces txd_o low |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |

## Verification
The transmitter is looped back into the receiver. Random bytes are sent with random multiprocessor bits, and each frame on txd_o is decoded bit by bit, so that a bit-order or position error is not hidden by a receiver with the same flaw. Directed runs check four timing points: the idle preamble length after enabling, the exact clock on which tend_o rises, a back-to-back pair that separates the holding register from the shifter, and an overrun. Frames with the bit clear, then set, then clear again are sent with the filter armed, which tells dropping apart from delivering and from the filter clearing itself. A bench-driven frame with a low stop bit and a break held during a frame complete the run.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 3;  // start, data, mpb, stop
  localparam int unsigned OSR     = 16;
  localparam int unsigned OSR_W   = $clog2(OSR);
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS
  } rx_state_e;
endpackage

// File: rtl/mp_uart_baud.sv
module mp_uart_baud #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_mpb_i,
  input  logic              tde_clr_i,
  output logic              tde_o,
  output logic              tend_o,
  output logic              line_o
);
  logic              en_q, busy_q, tde_q, tend_q, mpb_q;
  logic [DATA_W-1:0] hold_q;
  logic [FRAME_W-1:0] sr_q;
  logic [OSR_W-1:0]  sub_q;
  logic [BIT_W-1:0]  bit_q;
  logic rise, last_bit, load;

  assign rise     = en_i & ~en_q;
  assign last_bit = busy_q & tick_i & (sub_q == OSR_W'(OSR - 1)) & (bit_q == BIT_W'(FRAME_W - 1));
  assign load     = en_i & ~rise & ~tde_q & (~busy_q | last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      tde_q  <= 1'b1;
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
      hold_q <= '0;
      sr_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        busy_q <= 1'b0;
        tde_q  <= 1'b1;
        tend_q <= 1'b1;
        sr_q   <= '1;
      end else begin
        if (wr_i && tde_q) begin
          hold_q <= wr_data_i;
          mpb_q  <= wr_mpb_i;
        end
        if (rise) begin  // one frame time of marking
          busy_q <= 1'b1;
          sr_q   <= '1;
          sub_q  <= '0;
          bit_q  <= '0;
        end else if (load) begin
          busy_q <= 1'b1;
          sr_q   <= {1'b1, mpb_q, hold_q, 1'b0};
          sub_q  <= '0;
          bit_q  <= '0;
          tde_q  <= 1'b1;
        end else if (busy_q && tick_i) begin
          if (sub_q == OSR_W'(OSR - 1)) begin
            sub_q <= '0;
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
              busy_q <= 1'b0;
              tend_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        if (tde_clr_i && tde_q) begin  // commit wins over end-of-frame
          tde_q  <= 1'b0;
          tend_q <= 1'b0;
        end
      end
    end
  end

  assign tde_o  = tde_q;
  assign tend_o = tend_q;
  assign line_o = busy_q ? sr_q[0] : 1'b1;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              ack_i,
  input  logic              err_clr_i,
  input  logic              filt_set_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              filt_o
);
  localparam int unsigned SW = FRAME_W - 1;  // data, mpb, stop

  logic [1:0]       sync_q;
  logic             rxd_s;
  rx_state_e        st_q;
  logic [OSR_W-1:0] cnt_q;
  logic [BIT_W-1:0] idx_q;
  logic [SW-1:0]    shr_q, shr_nx;
  logic             done, take;

  assign rxd_s  = sync_q[1];
  assign shr_nx = {rxd_s, shr_q[SW-1:1]};
  assign done   = (st_q == RX_BITS) & tick_i & (cnt_q == OSR_W'(OSR - 1)) & (idx_q == BIT_W'(SW - 1));
  assign take   = done & (~filt_o | shr_nx[DATA_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shr_q <= '0;
    end else if (!en_i) begin
      st_q <= RX_IDLE;
    end else if (tick_i) begin
      unique case (st_q)
        RX_IDLE: if (!rxd_s) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: begin
          if (cnt_q == OSR_W'(OSR / 2 - 1)) begin  // mid start bit
            if (!rxd_s) begin
              st_q  <= RX_BITS;
              cnt_q <= '0;
              idx_q <= '0;
            end else begin
              st_q <= RX_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == OSR_W'(OSR - 1)) begin
            cnt_q <= '0;
            shr_q <= shr_nx;
            if (idx_q == BIT_W'(SW - 1)) st_q <= RX_IDLE;
            else                         idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mpb_o  <= 1'b0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      fer_o  <= 1'b0;
      filt_o <= 1'b0;
    end else begin
      if (ack_i)      full_o <= 1'b0;
      if (err_clr_i) begin
        ovr_o <= 1'b0;
        fer_o <= 1'b0;
      end
      if (filt_set_i) filt_o <= 1'b1;
      if (take) begin
        filt_o <= 1'b0;
        if (full_o) begin
          ovr_o  <= 1'b1;
          full_o <= 1'b1;
        end else begin
          data_o <= shr_nx[DATA_W-1:0];
          mpb_o  <= shr_nx[DATA_W];
          full_o <= 1'b1;
        end
        if (!shr_nx[SW-1]) fer_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_mpb_i,
  input  logic              tde_clr_i,
  output logic              tde_o,
  output logic              tend_o,
  input  logic              rd_ack_i,
  input  logic              err_clr_i,
  input  logic              filt_set_i,
  output logic              filt_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_mpb_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              fer_o,
  input  logic              brk_i,
  output logic              txd_o,
  input  logic              rxd_i
);
  logic tick, tx_line;

  mp_uart_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  mp_uart_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .en_i     (tx_en_i),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .wr_mpb_i (wr_mpb_i),
    .tde_clr_i(tde_clr_i),
    .tde_o    (tde_o),
    .tend_o   (tend_o),
    .line_o   (tx_line)
  );

  mp_uart_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .en_i      (rx_en_i),
    .rxd_i     (rxd_i),
    .ack_i     (rd_ack_i),
    .err_clr_i (err_clr_i),
    .filt_set_i(filt_set_i),
    .data_o    (rx_data_o),
    .mpb_o     (rx_mpb_o),
    .full_o    (rx_full_o),
    .ovr_o     (ovr_o),
    .fer_o     (fer_o),
    .filt_o    (filt_o)
  );

  // registered pin: glitch-free, break overrides everything
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_o <= 1'b1;
    else         txd_o <= brk_i ? 1'b0 : tx_line;
  end
endmodule

// File: rtl/mp_uart_chk.sv
module mp_uart_chk
  import mp_uart_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_i,
  input logic              tde_clr_i,
  input logic              tde_o,
  input logic              tend_o,
  input logic              rd_ack_i,
  input logic              filt_set_i,
  input logic              filt_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              brk_i,
  input logic              txd_o
);
  a_r11_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !txd_o);

  a_r1_mark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !$past(tx_en_i) && !brk_i) |=> txd_o);

  a_r5_tend_implies_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> tde_o);

  a_r4_commit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tde_o && tde_clr_i) |=> !tde_o);

  a_r7_filter_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_o && !filt_set_i) |=> !filt_o);

  a_r8_wake_delivers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_o) |-> rx_full_o);

  a_r9_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rd_ack_i) |=> $stable(rx_data_o));
endmodule

bind mp_uart mp_uart_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .tde_clr_i (tde_clr_i),
  .tde_o     (tde_o),
  .tend_o    (tend_o),
  .rd_ack_i  (rd_ack_i),
  .filt_set_i(filt_set_i),
  .filt_o    (filt_o),
  .rx_data_o (rx_data_o),
  .rx_full_o (rx_full_o),
  .brk_i     (brk_i),
  .txd_o     (txd_o)
);

// File: tb/mp_uart_tb.sv
module mp_uart_tb;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, wr = 0, wmpb = 0, tclr = 0, ack = 0, eclr = 0, fset = 0, brk = 0;
  logic [7:0] wdat = '0;
  logic loop_sel = 1'b1, drv = 1'b1;
  logic tde, tend, filt, rmpb, full, ovr, fer, txd, rxd;
  logic [7:0] rdat;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign rxd = loop_sel ? txd : drv;

  mp_uart #(.CLK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .wr_i(wr), .wr_data_i(wdat), .wr_mpb_i(wmpb), .tde_clr_i(tclr),
    .tde_o(tde), .tend_o(tend), .rd_ack_i(ack), .err_clr_i(eclr),
    .filt_set_i(fset), .filt_o(filt), .rx_data_o(rdat), .rx_mpb_o(rmpb),
    .rx_full_o(full), .ovr_o(ovr), .fer_o(fer), .brk_i(brk),
    .txd_o(txd), .rxd_i(rxd)
  );

  function automatic logic [10:0] mkframe(input logic [7:0] b, input logic m);
    return {1'b1, m, b, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic m);
    while (!tde) @(negedge clk);
    wr = 1; wdat = b; wmpb = m;
    @(negedge clk); wr = 0; tclr = 1;
    @(negedge clk); tclr = 0;
  endtask

  task automatic grab(output logic [10:0] f, output int waited);
    waited = 0;
    while (txd) begin @(negedge clk); waited++; end
    step(BIT / 2);
    for (int i = 0; i < 11; i++) begin
      f[i] = txd;
      if (i < 10) step(BIT);
    end
  endtask

  task automatic wait_full();
    while (!full) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic m, input logic stop);
    logic [10:0] f;
    f = {stop, m, b, 1'b0};
    for (int i = 0; i < 10; i++) begin drv = f[i]; step(BIT); end
    drv = stop; step(BIT / 2 + 8);
    drv = 1'b1; step(BIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] f;
    int w;
    logic [7:0] b, last;
    logic m;
    void'($urandom(32'd20240611));
    step(4); rst_n = 1; step(2);

    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 tde", tde, 1); chk("R1 tend", tend, 1);
    chk("R1 full", full, 0); chk("R1 ovr", ovr, 0); chk("R1 fer", fer, 0); chk("R1 filt", filt, 0);

    // R2 preamble, R3 first frame
    rx_en = 1; tx_en = 1;
    fork
      send(8'hA5, 1'b0);
      grab(f, w);
    join
    chk("R2 preamble window", (w >= 700 && w <= 708), 1);
    chk("R3 frame A5", f, mkframe(8'hA5, 0));
    wait_full();
    chk("R6 data", rdat, 8'hA5); chk("R6 mpb", rmpb, 0);
    pulse_ack(); chk("R6 ack clears", full, 0);
    last = 8'hA5;

    // random frames through the loopback
    for (int k = 0; k < 12; k++) begin
      b = 8'($urandom); m = 1'($urandom);
      fork
        send(b, m);
        grab(f, w);
      join
      chk("R3 random frame", f, mkframe(b, m));
      wait_full();
      chk("R6 random data", rdat, b); chk("R6 random mpb", rmpb, m);
      pulse_ack();
      last = b;
    end
    while (!tend) @(negedge clk);
    step(BIT);

    // R5 exact end timing on idle transmitter
    send(8'h5A, 1'b1);
    chk("R4 committed", tde, 0);
    step(699); chk("R5 tend before stop end", tend, 0);
    step(6);   chk("R5 tend after stop end", tend, 1);
    wait_full(); pulse_ack();
    step(BIT);

    // R4 double buffer, R9 overrun
    send(8'h11, 1'b0);
    chk("R4 tde low after commit", tde, 0);
    step(1);
    chk("R4 tde back on load", tde, 1); chk("R5 tend low while shifting", tend, 0);
    send(8'h22, 1'b0);
    chk("R4 second held", tde, 0);
    step(5 * BIT);
    chk("R4 second still waiting", tde, 0);
    wait_full();
    chk("R6 first of pair", rdat, 8'h11);
    step(11 * BIT + 40);
    chk("R9 overrun", ovr, 1); chk("R9 old data kept", rdat, 8'h11); chk("R9 still full", full, 1);
    chk("R5 tend after pair", tend, 1);
    pulse_ack(); eclr = 1; @(negedge clk); eclr = 0;
    chk("R10 clear ovr", ovr, 0);
    last = 8'h11;

    // R7 R8 address filter
    fset = 1; @(negedge clk); fset = 0;
    chk("R7 armed", filt, 1);
    for (int k = 0; k < 2; k++) begin
      send(8'($urandom), 1'b0);
      while (!tend) @(negedge clk);
      step(BIT);
      chk("R7 dropped no full", full, 0); chk("R7 data unchanged", rdat, last);
      chk("R7 filter stays", filt, 1);
    end
    send(8'h81, 1'b1);
    wait_full();
    chk("R8 id data", rdat, 8'h81); chk("R8 id mpb", rmpb, 1); chk("R8 filter cleared", filt, 0);
    pulse_ack();
    send(8'h42, 1'b0);
    wait_full();
    chk("R8 following data", rdat, 8'h42); chk("R8 following mpb", rmpb, 0);
    pulse_ack();
    while (!tend) @(negedge clk);
    step(BIT);

    // R10 framing error from bench-driven line
    loop_sel = 0; drv = 1; step(4);
    drive_frame(8'h96, 1'b0, 1'b0);
    chk("R10 fer set", fer, 1); chk("R10 data", rdat, 8'h96); chk("R10 full", full, 1);
    pulse_ack(); eclr = 1; @(negedge clk); eclr = 0;
    chk("R10 clear fer", fer, 0);
    drive_frame(8'h3C, 1'b1, 1'b1);
    chk("R10 good stop", fer, 0); chk("R6 bench frame", rdat, 8'h3C);
    pulse_ack();
    loop_sel = 1;

    // R11 break mid-frame, then disable
    send(8'hFF, 1'b1);
    while (txd) @(negedge clk);
    step(3 * BIT);
    brk = 1; step(2);
    for (int k = 0; k < 4; k++) begin
      chk("R11 break low", txd, 0);
      step(40);
    end
    tx_en = 0; step(3);
    chk("R11 low after disable", txd, 0);
    chk("R1 tde when off", tde, 1); chk("R1 tend when off", tend, 1);
    brk = 0; step(3);
    chk("R1 mark when off", txd, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule